// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is an 8-bit arithmetic and logic unit wrapped around its own accumulator and a five-flag status byte. Each clock cycle in which `op_valid` is high, it applies one operation, selected by `op_code`, to the accumulator and, where the operation takes one, the already-resolved 8-bit `operand`. It then registers the new accumulator value and the updated flag byte. Both are visible on the outputs from the clock edge that accepted the operation.

The operations are:
- load, add and subtract;
- increment and decrement of the accumulator;
- AND, OR and XOR;
- complement;
- compare;
- two rotate pairs. One pair copies the bit shifted out into both the carry and the opposite end. The other pair passes the old carry into the vacated bit.

Each operation updates its own subset of the flags. The other flags keep their previous values.

Top module: `acc_alu`

## Requirements
- R1: The flag byte places sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0. An active-low asynchronous reset clears the accumulator and the flag byte to 00h.
- R2: For add, subtract, increment, decrement, AND, OR, XOR and compare, these flags are taken from the 8-bit result (for compare, the difference):
  - sign equals bit 7 of the result;
  - zero is 1 when the result is 00h;
  - parity is 1 when the result holds an even number of ones.
- R3: Add (code 2) writes (accumulator + operand) mod 256. Carry is the carry out of bit 7. Auxiliary carry is the carry out of bit 3.
- R4: Subtract (code 3) writes (accumulator − operand) mod 256. Carry is 1 when operand > accumulator (borrow). Auxiliary carry is 1 when the low nibble of the operand exceeds that of the accumulator.
- R5: Increment (code 4) and decrement (code 5) add or subtract 1 to or from the accumulator, and the operand is ignored. Carry keeps its previous value. Auxiliary carry is 1 when the old low nibble was Fh for increment, or 0h for decrement.
- R6: AND (code 6), OR (code 7) and XOR (code 8) combine the accumulator bitwise with the operand and clear both carry and auxiliary carry.
- R7: Complement (code 9) inverts every accumulator bit, ignores the operand and leaves the whole flag byte unchanged.
- R8: Compare (code 10) sets all five flags exactly as subtract would, and leaves the accumulator unchanged.
- R9: Rotate-left-circular (code 11) moves bit 7 into bit 0 and into carry. Rotate-right-circular (code 13) moves bit 0 into bit 7 and into carry. The other four flags keep their values.
- R10: Rotate-left-through-carry (code 12) moves bit 7 into carry and the old carry into bit 0. Rotate-right-through-carry (code 14) moves bit 0 into carry and the old carry into bit 7. The other four flags keep their values.
- R11: Load (code 1) copies the operand into the accumulator and keeps the flags. The following change neither the accumulator nor the flags:
  - code 0;
  - code 15;
  - any code presented with `op_valid` low.
- R12: An operation sampled at a rising edge with `op_valid` high appears on `acc` and `flags` right after that same edge. Operations issued back to back each take one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Apply `op_code` at this edge |
| op_code | input | 4 | Operation select (codes in R3–R11) |
| operand | input | 8 | Resolved 8-bit operand |
| acc | output | 8 | Registered accumulator |
| flags | output | 8 | Registered status byte (layout in R1) |

## Verification
Every result is due one edge after its operation is sampled: the accumulator and every flag change together at the edge that accepts the operation, and no result takes longer. The bench drives each operation on a falling edge and compares both outputs on the next falling edge. That point is half a period after the edge that produced the result and half a period before the next operation is taken. Before each operation, the bench forces the carry to a known value and loads the accumulator. Every one of those setup steps is also compared in the same cycle. As a result, the carry-in dependence of the through-carry rotates and the flags kept by complement and load are checked at each step.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int ACC_W  = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 4;

    // flag bit positions inside the status byte
    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_AC = 4;
    localparam int FLG_P  = 2;
    localparam int FLG_CY = 0;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_LOAD = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_CPL  = 4'd9,
        OP_CMP  = 4'd10,
        OP_RLC  = 4'd11,
        OP_RAL  = 4'd12,
        OP_RRC  = 4'd13,
        OP_RAR  = 4'd14,
        OP_RSV  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] flg;
    } alu_state_t;

    function automatic logic [ACC_W-1:0] pack_flags(
        input logic s, input logic z, input logic ac,
        input logic p, input logic cy);
        logic [ACC_W-1:0] f;
        f          = '0;
        f[FLG_S]   = s;
        f[FLG_Z]   = z;
        f[FLG_AC]  = ac;
        f[FLG_P]   = p;
        f[FLG_CY]  = cy;
        return f;
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
// Shared adder for add, subtract, increment, decrement and compare.
// Subtraction is done as a + ~b + 1; carry outs are inverted into borrows.
module acc_alu_arith #(
    parameter int W   = acc_alu_pkg::ACC_W,
    parameter int NW  = acc_alu_pkg::NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cy,
    output logic         hc
);
    logic [W-1:0] b_eff;
    logic [W:0]   full_sum;
    logic [NW:0]  low_sum;

    always_comb begin
        b_eff    = sub ? ~b : b;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        low_sum  = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, sub};
        res      = full_sum[W-1:0];
        cy       = sub ? ~full_sum[W] : full_sum[W];
        hc       = sub ? ~low_sum[NW] : low_sum[NW];
    end
endmodule

// File: rtl/acc_alu_bitops.sv
// Bitwise operations, complement and the four rotates.
module acc_alu_bitops #(
    parameter int W = acc_alu_pkg::ACC_W
) (
    input  acc_alu_pkg::alu_op_e op,
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    input  logic                 cy_in,
    output logic [W-1:0]         res,
    output logic                 cy_out
);
    import acc_alu_pkg::*;

    always_comb begin
        res    = a;
        cy_out = cy_in;
        unique case (op)
            OP_AND: begin res = a & b; cy_out = 1'b0; end
            OP_OR:  begin res = a | b; cy_out = 1'b0; end
            OP_XOR: begin res = a ^ b; cy_out = 1'b0; end
            OP_CPL: res = ~a;
            OP_RLC: begin res = {a[W-2:0], a[W-1]}; cy_out = a[W-1]; end
            OP_RAL: begin res = {a[W-2:0], cy_in};  cy_out = a[W-1]; end
            OP_RRC: begin res = {a[0], a[W-1:1]};   cy_out = a[0];   end
            OP_RAR: begin res = {cy_in, a[W-1:1]};  cy_out = a[0];   end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_status.sv
// Sign, zero and even-parity of a result.
module acc_alu_status #(
    parameter int W = acc_alu_pkg::ACC_W
) (
    input  logic [W-1:0] res,
    output logic         sgn,
    output logic         zro,
    output logic         par
);
    always_comb begin
        sgn = res[W-1];
        zro = (res == '0);
        par = ~^res;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [3:0] op_code,
    input  logic [7:0] operand,
    output logic [7:0] acc,
    output logic [7:0] flags
);
    import acc_alu_pkg::*;

    localparam int W = ACC_W;

    alu_state_t state_d, state_q;
    alu_op_e    op_sel;

    logic [W-1:0] ar_b, ar_res, bo_res;
    logic         ar_sub, ar_cy, ar_hc, bo_cy;
    logic         ar_s, ar_z, ar_p, bo_s, bo_z, bo_p;

    assign op_sel = alu_op_e'(op_code);

    always_comb begin
        ar_sub = (op_sel == OP_SUB) || (op_sel == OP_CMP) || (op_sel == OP_DEC);
        ar_b   = ((op_sel == OP_INC) || (op_sel == OP_DEC)) ? W'(1) : operand;
    end

    acc_alu_arith #(.W(W), .NW(NIB_W)) u_arith (
        .a   (state_q.acc),
        .b   (ar_b),
        .sub (ar_sub),
        .res (ar_res),
        .cy  (ar_cy),
        .hc  (ar_hc)
    );

    acc_alu_bitops #(.W(W)) u_bitops (
        .op     (op_sel),
        .a      (state_q.acc),
        .b      (operand),
        .cy_in  (state_q.flg[FLG_CY]),
        .res    (bo_res),
        .cy_out (bo_cy)
    );

    acc_alu_status #(.W(W)) u_st_arith (
        .res (ar_res), .sgn (ar_s), .zro (ar_z), .par (ar_p)
    );

    acc_alu_status #(.W(W)) u_st_bitops (
        .res (bo_res), .sgn (bo_s), .zro (bo_z), .par (bo_p)
    );

    always_comb begin
        state_d = state_q;
        if (op_valid) begin
            unique case (op_sel)
                OP_LOAD: state_d.acc = operand;
                OP_ADD, OP_SUB: begin
                    state_d.acc = ar_res;
                    state_d.flg = pack_flags(ar_s, ar_z, ar_hc, ar_p, ar_cy);
                end
                OP_INC, OP_DEC: begin
                    state_d.acc = ar_res;
                    state_d.flg = pack_flags(ar_s, ar_z, ar_hc, ar_p,
                                             state_q.flg[FLG_CY]);
                end
                OP_CMP:
                    state_d.flg = pack_flags(ar_s, ar_z, ar_hc, ar_p, ar_cy);
                OP_AND, OP_OR, OP_XOR: begin
                    state_d.acc = bo_res;
                    state_d.flg = pack_flags(bo_s, bo_z, 1'b0, bo_p, bo_cy);
                end
                OP_CPL: state_d.acc = bo_res;
                OP_RLC, OP_RAL, OP_RRC, OP_RAR: begin
                    state_d.acc = bo_res;
                    state_d.flg[FLG_CY] = bo_cy;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign acc   = state_q.acc;
    assign flags = state_q.flg;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [3:0] op_code,
    input logic [7:0] operand,
    input logic [7:0] acc,
    input logic [7:0] flags
);
    logic upd_szp, is_rot, is_bit;

    assign upd_szp = op_valid && (op_code inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8});
    assign is_rot  = op_valid && (op_code inside {4'd11, 4'd12, 4'd13, 4'd14});
    assign is_bit  = op_valid && (op_code inside {4'd6, 4'd7, 4'd8});

    AST_UNUSED_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[5] == 1'b0) && (flags[3] == 1'b0) && (flags[1] == 1'b0)); // R1

    AST_SZP_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_szp |=> (flags[7] == acc[7]) && (flags[6] == (acc == 8'h00))
                    && (flags[2] == ~^acc)); // R2

    AST_INCDEC_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code inside {4'd4, 4'd5})) |=> $stable(flags[0])); // R5

    AST_BITWISE_CLEAR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        is_bit |=> (flags[0] == 1'b0) && (flags[4] == 1'b0)); // R6

    AST_CPL_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd9) |=> (acc == ~$past(acc)) && $stable(flags)); // R7

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd10) |=> $stable(acc)); // R8

    AST_RLC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd11) |=> (acc[0] == $past(acc[7])) && (flags[0] == $past(acc[7]))); // R9

    AST_ROT_ONLY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        is_rot |=> $stable(flags[7:1])); // R10

    AST_RAR_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd14) |=> (acc[7] == $past(flags[0])) && (flags[0] == $past(acc[0]))); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == 4'd0 || op_code == 4'd15) |=> $stable(acc) && $stable(flags)); // R11

endmodule

bind acc_alu acc_alu_chk u_chk (.*);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] operand = 8'd0;
    logic [7:0] acc;
    logic [7:0] flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_acc = 0;
    int m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

    always #5 clk = ~clk;

    acc_alu u0 (.*);

    function automatic string req_of(int op);
        case (op)
            1: return "R11";  2: return "R3";  3: return "R4";
            4: return "R5";   5: return "R5";  6: return "R6";
            7: return "R6";   8: return "R6";  9: return "R7";
            10: return "R8";  11: return "R9"; 12: return "R10";
            13: return "R9";  14: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int even_ones(int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return (n % 2 == 0) ? 1 : 0;
    endfunction

    task automatic set_szp(int r);
        m_s = r / 128;
        m_z = (r == 0) ? 1 : 0;
        m_p = even_ones(r);
    endtask

    function automatic int m_flags();
        return m_s * 128 + m_z * 64 + m_ac * 16 + m_p * 4 + m_cy;
    endfunction

    task automatic model(int op, int b);
        int r, nc;
        case (op)
            1: m_acc = b;
            2: begin r = m_acc + b; m_cy = (r > 255); m_ac = ((m_acc % 16) + (b % 16)) > 15;
                     m_acc = r % 256; set_szp(m_acc); end
            3: begin m_cy = (m_acc < b); m_ac = (m_acc % 16) < (b % 16);
                     m_acc = (m_acc - b + 256) % 256; set_szp(m_acc); end
            4: begin m_ac = (m_acc % 16) == 15; m_acc = (m_acc + 1) % 256; set_szp(m_acc); end
            5: begin m_ac = (m_acc % 16) == 0; m_acc = (m_acc + 255) % 256; set_szp(m_acc); end
            6: begin m_acc = m_acc & b; m_cy = 0; m_ac = 0; set_szp(m_acc); end
            7: begin m_acc = m_acc | b; m_cy = 0; m_ac = 0; set_szp(m_acc); end
            8: begin m_acc = m_acc ^ b; m_cy = 0; m_ac = 0; set_szp(m_acc); end
            9: m_acc = 255 - m_acc;
            10: begin r = (m_acc - b + 256) % 256; m_cy = (m_acc < b);
                      m_ac = (m_acc % 16) < (b % 16); set_szp(r); end
            11: begin m_cy = m_acc / 128; m_acc = (m_acc * 2) % 256 + m_cy; end
            12: begin nc = m_acc / 128; m_acc = (m_acc * 2) % 256 + m_cy; m_cy = nc; end
            13: begin m_cy = m_acc % 2; m_acc = m_acc / 2 + m_cy * 128; end
            14: begin nc = m_acc % 2; m_acc = m_acc / 2 + m_cy * 128; m_cy = nc; end
            default: ;
        endcase
    endtask

    task automatic compare(string req);
        checks++;
        if (acc !== 8'(m_acc) || flags !== 8'(m_flags())) begin
            errors++;
            $display("FAIL %s acc=%h exp %h flags=%h exp %h", req, acc, 8'(m_acc), flags, 8'(m_flags()));
        end
    endtask

    // drive at a falling edge; result registered at the next rising edge (R12)
    task automatic do_op(int op, int b, bit vld);
        op_valid = vld;
        op_code  = 4'(op);
        operand  = 8'(b);
        if (vld) model(op, b);
        @(negedge clk);
        compare(vld ? req_of(op) : "R11");
    endtask

    task automatic force_carry(int c);
        if (c != 0) begin do_op(1, 255, 1); do_op(2, 1, 1); end
        else begin do_op(1, 0, 1); do_op(2, 0, 1); end
    endtask

    function automatic int pick(int i, int k);
        if (i == 0) return 0;
        if (i == 15) return 255;
        if (i == 7) return 128;
        return (i * k + 3) % 256;
    endfunction

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset clears accumulator and flags
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R12: back-to-back single-cycle ops
        do_op(1, 8'h3A, 1);
        do_op(2, 8'hC6, 1);
        do_op(4, 0, 1);
        do_op(12, 0, 1);

        // near-exhaustive sweep over ops, operands and carry-in
        for (int op = 1; op <= 14; op++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    for (int c = 0; c < 2; c++) begin
                        force_carry(c);
                        do_op(1, pick(i, 53), 1);
                        do_op(op, pick(j, 29), 1);
                    end

        // R11: idle codes and op_valid low leave state untouched
        do_op(1, 8'h5C, 1);
        do_op(2, 8'hB7, 1);
        for (int op = 0; op < 16; op++) do_op(op, 8'hFF, 0);
        do_op(0, 8'h12, 1);
        do_op(15, 8'h34, 1);

        // R1: asynchronous reset in mid-run
        #2 rst_n = 1'b0;
        m_acc = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
        #1 compare("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule